// File: doc/BRIEF.md
# Synchronous Burst SRAM with Selectable Output Path

This block is a synthesizable, parameter-sized model of a synchronous burst SRAM. Its default size is 256 words of 36 bits, split into four 9-bit byte lanes. Every control input is sampled on the rising clock edge except output enable, which acts combinationally. All control inputs are active low.

An access starts on one of two address strobes: a processor strobe or a controller strobe. Once started, an access can continue as a four-beat burst. The burst address wraps inside its aligned four-word block, and an advance input steps it or holds it. A new address may be presented on every cycle, so bursts are optional. Writes can be per-lane byte writes or a global write that covers every lane.

A static mode input selects the read path. In flow-through mode the data comes straight from the array. In pipelined mode it passes through an output register, which adds one cycle. A deselect flows down the same valid pipeline as a read, so in pipelined mode the bus stops driving one cycle after the deselect edge. Pad drivers are represented by a data output and a drive-enable output.

Top module: `burst_sram`

## Requirements
- R1: All inputs except `oe_n` take effect only at a rising clock edge. A read accepted at the edge after a write to the same address returns the newly written word.
- R2: With `pipe_sel`=0 (flow-through), a read accepted at edge k is driven on `dq_o` with `dq_oe`=1 during the cycle after edge k (2-1-1-1 timing).
- R3: With `pipe_sel`=1 (pipelined), a read accepted at edge k is driven during the cycle after edge k+1 (3-1-1-1 timing).
- R4: With `ce_n`=0, `adsp_n`=1 and `adsc_n`=0, an access starts at `addr`. It is a write if `gw_n`=0, or if `bwe_n`=0 with at least one `bs_n` bit low. Otherwise it is a read.
- R5: With `ce_n`=0 and `adsp_n`=0, a read starts at `addr`, and all write controls are ignored in that cycle.
- R6: In a byte write, a low `bs_n[k]` writes only bits [9k+8:9k]. All other lanes keep their contents.
- R7: `gw_n`=0 writes all lanes, whatever `bwe_n` and `bs_n` are.
- R8: While a burst is active with `ce_n`=0 and both strobes high, `adv_n`=0 moves to the next address and `adv_n`=1 repeats the current address. The next address increments the two low address bits modulo 4 and keeps the upper bits. Each such beat reads or writes according to the write controls.
- R9: `ce_n`=1, or a cycle with no strobe and no active burst, is a deselect that ends the burst. In pipelined mode the bus keeps driving the prior read for one full cycle after the deselect edge and stops after the following edge. In flow-through mode it stops right after the deselect edge.
- R10: `dq_oe`=0 and `dq_o`=0 whenever `oe_n`=1 or the selected output slot holds no read. `oe_n` changes the drive without any clock edge.
- R11: A synchronous reset (`rst`=1 at an edge) ends any burst and clears the output valid pipeline, so `dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pipe_sel | input | 1 | 1 selects the registered output path, 0 selects flow-through |
| ce_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low (read only) |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bs_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled with the write |
| dq_o | output | LANES*LANE_W | Read data, zero when not driving |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Assertions check on every cycle the latency links between an accepted read and the bus drive in both output modes. They also check that continuation beats keep the upper address bits of their aligned block, that a held advance repeats the address, and that the processor strobe never opens a write. The bench scenarios are needed for stored contents: byte-lane masking, the global-write override, read-after-write, and burst writes. They also cover the one-cycle tail after a deselect seen together with data, the combinational effect of output enable, and the effect of a reset in the middle of a burst.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int LANES   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bs_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc_kind,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  lane_we
);

  logic               act_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               start_p, start_c, cont, wr_req;
  logic [BURST_W-1:0] nxt_cnt, low_bits;

  always_comb begin
    start_p  = !ce_n && !adsp_n;
    start_c  = !ce_n && adsp_n && !adsc_n;
    cont     = !ce_n && adsp_n && adsc_n && act_q;
    wr_req   = !gw_n || (!bwe_n && !(&bs_n));
    nxt_cnt  = adv_n ? cnt_q : cnt_q + BURST_W'(1);
    low_bits = base_q[BURST_W-1:0] + nxt_cnt;
    acc_kind = ACC_NONE;
    acc_addr = addr;
    lane_we  = '0;
    if (start_p) begin
      acc_kind = ACC_READ;
    end else if (start_c || cont) begin
      if (cont) acc_addr = {base_q[ADDR_W-1:BURST_W], low_bits};
      acc_kind = wr_req ? ACC_WRITE : ACC_READ;
      if (wr_req) lane_we = gw_n ? ~bs_n : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (start_p || start_c) begin
      act_q  <= 1'b1;
      base_q <= addr;
      cnt_q  <= '0;
    end else if (cont) begin
      cnt_q  <= nxt_cnt;
    end else begin
      act_q  <= 1'b0;
    end
  end

  // R8
  burst_block_chk: assert property (@(posedge clk) disable iff (rst)
    cont |-> acc_addr[ADDR_W-1:BURST_W] == $past(acc_addr[ADDR_W-1:BURST_W]));

  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cont && adv_n) |-> acc_addr == $past(acc_addr));

  // R5
  adsp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !adsp_n) |-> (lane_we == '0 && acc_kind == ACC_READ));

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        we,
  input  logic                    rd_en,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 2 ** ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en) rd_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sram_out_path.sv
module sram_out_path #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_sel,
  input  logic              oe_n,
  input  logic              rd_acc,
  input  logic [DATA_W-1:0] arr_q,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);

  logic              v1_q, v2_q;
  logic [DATA_W-1:0] oreg_q;
  logic              sel_v;
  logic [DATA_W-1:0] sel_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      oreg_q <= '0;
    end else begin
      v1_q   <= rd_acc;
      v2_q   <= v1_q;
      oreg_q <= arr_q;
    end
  end

  always_comb begin
    sel_v = pipe_sel ? v2_q : v1_q;
    sel_d = pipe_sel ? oreg_q : arr_q;
    dq_oe = sel_v && !oe_n;
    dq_o  = dq_oe ? sel_d : '0;
  end

  // R3
  pipe_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe_sel && dq_oe) |-> $past(rd_acc, 2));

  // R2
  flow_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe_sel && dq_oe) |-> $past(rd_acc));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pipe_sel,
  input  logic                    ce_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bs_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  acc_e              acc_kind;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] arr_q;
  logic              rd_acc;

  assign rd_acc = (acc_kind == ACC_READ);

  sram_burst_ctl #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W),
    .LANES  (LANES)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .adv_n   (adv_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bs_n    (bs_n),
    .addr    (addr),
    .acc_kind(acc_kind),
    .acc_addr(acc_addr),
    .lane_we (lane_we)
  );

  sram_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_arr (
    .clk  (clk),
    .addr (acc_addr),
    .we   (lane_we),
    .rd_en(rd_acc),
    .wdata(wdata),
    .rdata(arr_q)
  );

  sram_out_path #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .pipe_sel(pipe_sel),
    .oe_n    (oe_n),
    .rd_acc  (rd_acc),
    .arr_q   (arr_q),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe)
  );

endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
  localparam int PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic        ce_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n;
    logic [3:0]  bs_n;
    logic        oe_n;
    logic [7:0]  addr;
    logic [35:0] wd;
    logic        x_oe;
    logic [35:0] x_d;
    logic [3:0]  req;
  } vec_t;

  // Pipelined mode: a check at row i sees the access accepted two rows earlier.
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,8'h10,36'h123456789,1'b0,36'h0,4'd11}, // R11 out of reset
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,8'h11,36'hFEDCBA987,1'b0,36'h0,4'd4},  // R4 writes
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'h5,1'b0,8'h11,36'h000000000,1'b0,36'h0,4'd6},  // R6 lanes 1,3
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'hE,1'b0,8'h12,36'hABCDE0123,1'b0,36'h0,4'd7},  // R7 override
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,8'h13,36'h0F0F0F0F0,1'b0,36'h0,4'd4},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,8'h10,36'h000000000,1'b0,36'h0,4'd5},  // R5 gw ignored
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,8'h11,36'h0,1'b0,36'h0,4'd3},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,8'h12,36'h0,1'b1,36'h123456789,4'd5},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b1,36'h005C80187,4'd6},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b1,36'hABCDE0123,4'd9},  // R9 tail cycle
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,8'h12,36'h0,1'b0,36'h0,4'd9},          // R9 off
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b0,36'h0,4'd9},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b1,36'hABCDE0123,4'd3},  // R3
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b1,36'h0F0F0F0F0,4'd8},  // R8 beat 0x13
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b1,36'h123456789,4'd8},  // R8 wrap 0x10
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,8'h10,36'h0,1'b0,36'h0,4'd10},         // R10 hidden
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b1,36'h005C80187,4'd8},  // R8 held 0x11
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b1,36'h123456789,4'd3},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b1,36'h005C80187,4'd8},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,8'h00,36'h0,1'b0,36'h0,4'd9}
  };

  logic        clk = 1'b0;
  logic        rst, pipe_sel, ce_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
  logic [3:0]  bs_n;
  logic [7:0]  addr;
  logic [35:0] wdata, dq_o;
  logic        dq_oe;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  burst_sram u0 (
    .clk(clk), .rst(rst), .pipe_sel(pipe_sel), .ce_n(ce_n), .adsp_n(adsp_n),
    .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bs_n(bs_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic drive(input logic c, input logic p, input logic s, input logic a,
                       input logic g, input logic b, input logic [3:0] bs,
                       input logic [7:0] ad, input logic [35:0] wd);
    ce_n = c; adsp_n = p; adsc_n = s; adv_n = a;
    gw_n = g; bwe_n = b; bs_n = bs; addr = ad; wdata = wd;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 8'h00, 36'h0);
  endtask

  task automatic chk(input string tag, input logic x_oe, input logic [35:0] x_d);
    n_cmp++;
    if (dq_oe !== x_oe || (x_oe && dq_o !== x_d) || (!x_oe && dq_o !== 36'h0)) begin
      n_bad++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
               tag, dq_oe, dq_o, x_oe, x_oe ? x_d : 36'h0);
    end
  endtask

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pipe_sel = 1'b1; oe_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    #1 chk("R11 reset", 1'b0, 36'h0);
    rst = 1'b0;

    // Vector table, pipelined mode
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i].ce_n, VT[i].adsp_n, VT[i].adsc_n, VT[i].adv_n,
            VT[i].gw_n, VT[i].bwe_n, VT[i].bs_n, VT[i].addr, VT[i].wd);
      oe_n = VT[i].oe_n;
      #1 chk($sformatf("R%0d row %0d", VT[i].req, i), VT[i].x_oe, VT[i].x_d);
    end

    // Flow-through: R1 read-after-write, R2 latency
    @(negedge clk); idle(); pipe_sel = 1'b0;
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 8'h20, 36'h555555555);
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 8'h20, 36'h0);
    #1 chk("R1 write slot idle", 1'b0, 36'h0);
    @(negedge clk); idle();
    #1 chk("R2 flow read-after-write", 1'b1, 36'h555555555);
    @(negedge clk); idle();
    #1 chk("R9 flow deselect", 1'b0, 36'h0);

    // Burst write in flow-through mode, then read second beat (R8)
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 8'h30, 36'h111111111);
    @(negedge clk); drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'h00, 36'h222222222);
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 8'h31, 36'h0);
    @(negedge clk); idle();
    #1 chk("R8 burst write beat", 1'b1, 36'h222222222);

    // Asynchronous output enable (R10)
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 8'h30, 36'h0);
    @(negedge clk); idle();
    #1 chk("R2 flow read", 1'b1, 36'h111111111);
    oe_n = 1'b1;
    #1 chk("R10 oe off mid-cycle", 1'b0, 36'h0);
    oe_n = 1'b0;
    #1 chk("R10 oe on mid-cycle", 1'b1, 36'h111111111);

    // Reset in mid-burst, pipelined (R11)
    @(negedge clk); pipe_sel = 1'b1;
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 8'h30, 36'h0);
    @(negedge clk); drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 8'h00, 36'h0); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 chk("R11 cleared by reset", 1'b0, 36'h0);
    @(negedge clk); idle();
    #1 chk("R11 burst ended", 1'b0, 36'h0);
    @(negedge clk);
    #1 chk("R11 no stray beat", 1'b0, 36'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule